// File: doc/BRIEF.md
# Peak-and-Hold PWM Load Driver

This block is the digital controller behind a low-side switch that drives a solenoid, valve or similar coil. When the enable input goes high, the gate drive stays fully on for a programmable pull-in interval. This gives the load a strong initial closure. The controller then drops to a fixed-frequency pulse-width hold mode, which keeps the load closed while dissipating far less power.

The hold duty comes from a digital code and is saturated to a 10 % to 90 % band. The carrier counter runs freely from reset and is never restarted by enable. A new duty code is taken up only at the start of a carrier period. The pull-in length is counted in prescaled clock ticks. One reserved length value keeps the switch on indefinitely.

A thermal fault input acts like a dropped enable: it forces the switch off and clears the pull-in timer. When the fault clears while enable is still high, a fresh pull-in begins. A mode output reports whether the block is idle, pulling in or holding.

Top module: `pnh_driver`

## Requirements
- R1: With enable high and no thermal fault, an idle block enters pull-in at the next clock edge, and `gate_o` stays high for every cycle of pull-in.
- R2: With `pull_len_i` = L (not all-ones), pull-in lasts exactly (L+1)*PRESC clock cycles, after which the block enters hold. L = 0 gives the shortest pull-in of PRESC cycles.
- R3: With `pull_len_i` all-ones, pull-in never ends while enable stays high and no fault is present.
- R4: In hold, `gate_o` repeats every PERIOD cycles and is high for the first ON cycles of each period. The carrier phase is set only by reset and is not shifted by enable.
- R5: ON = clamp(code)*PERIOD / 2^DUTY_W (rounded down). Clamp raises codes below LO = ceil(2^DUTY_W/10) to LO and lowers codes above HI = floor(9*2^DUTY_W/10) to HI, so ON never falls as the code rises.
- R6: A change of `duty_code_i` during a period does not alter that period. It takes effect from the next period start.
- R7: Enable low forces `gate_o` low and mode to idle after the next clock edge.
- R8: `thermal_i` high forces `gate_o` low and mode to idle after the next clock edge. The block stays idle for as long as the fault lasts.
- R9: When the fault clears with enable high, the block restarts a full pull-in and does not return directly to hold.
- R10: `mode_o` encodes idle = 0, pull-in = 1, hold = 2. During and after reset, `gate_o` is 0 and `mode_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| enable_i | input | 1 | Run request for the load |
| thermal_i | input | 1 | Over-temperature fault, high while hot |
| duty_code_i | input | DUTY_W | Hold duty as a fraction of 2^DUTY_W |
| pull_len_i | input | PULL_W | Pull-in length in prescaled ticks minus one; all-ones means endless |
| gate_o | output | 1 | Drive for the low-side switch |
| mode_o | output | 2 | Idle / pull-in / hold indication |

## Verification
Each block of state shows up at the ports quickly if it is wrong:
- A wrong sequencer state is visible on `mode_o` at the very next sample.
- A pull-in timer that is off by a tick moves the pull-in to hold change by PRESC cycles.
- A faulty carrier counter or duty latch changes either the spacing of `gate_o` rising edges or the count of high cycles within one PERIOD window.
- A duty latched at the wrong moment is exposed inside the period in which the code changes.

Carrier phase is checked by comparing rising-edge times across a disable and re-enable. The spacing must remain a multiple of PERIOD.

// File: rtl/pnh_pkg.sv
package pnh_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_PULL = 2'd1,
    MODE_HOLD = 2'd2
  } pnh_mode_e;
endpackage

// File: rtl/pnh_duty_map.sv
// Saturates the duty code to the 10..90 % band and scales it to carrier ticks.
module pnh_duty_map #(
  parameter int PERIOD = 5208,
  parameter int DUTY_W = 8,
  parameter int TICK_W = 13
) (
  input  logic [DUTY_W-1:0] code_i,
  output logic [TICK_W-1:0] on_ticks_o
);
  localparam int FULL   = 1 << DUTY_W;
  localparam int LO     = (FULL + 9) / 10;
  localparam int HI     = (9 * FULL) / 10;
  localparam int PROD_W = DUTY_W + TICK_W;

  logic [DUTY_W-1:0] clamped;
  logic [PROD_W-1:0] prod;

  always_comb begin
    if (code_i < DUTY_W'(LO))      clamped = DUTY_W'(LO);
    else if (code_i > DUTY_W'(HI)) clamped = DUTY_W'(HI);
    else                           clamped = code_i;
    prod       = PROD_W'(clamped) * PROD_W'(PERIOD);
    on_ticks_o = TICK_W'(prod >> DUTY_W);
  end
endmodule

// File: rtl/pnh_carrier.sv
// Free-running carrier with duty latched at the period boundary.
module pnh_carrier #(
  parameter int PERIOD    = 5208,
  parameter int TICK_W    = 13,
  parameter int MIN_TICKS = 520,
  parameter int MAX_TICKS = 4680
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] on_ticks_i,
  output logic              pwm_o
);
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [TICK_W-1:0] duty_q, duty_d;
  logic              wrap;

  always_comb begin
    wrap   = (cnt_q == CNT_W'(PERIOD - 1));
    cnt_d  = wrap ? '0 : cnt_q + 1'b1;
    duty_d = wrap ? on_ticks_i : duty_q;
    pwm_o  = (TICK_W'(cnt_q) < duty_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      duty_q <= TICK_W'(MIN_TICKS);
    end else begin
      cnt_q <= cnt_d;
      if (wrap) duty_q <= duty_d;
    end
  end

  // R4: the counter stays inside the period and restarts after its last tick
  a_r4_carrier_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(PERIOD - 1)) |=> (cnt_q == '0));
  a_r4_carrier_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q < CNT_W'(PERIOD)));
  // R6: the latched duty moves only at a period boundary
  a_r6_duty_latched_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(duty_q));
  // R5: the latched on-time is always inside the saturated band
  a_r5_duty_in_band: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q >= TICK_W'(MIN_TICKS)) && (duty_q <= TICK_W'(MAX_TICKS)));
endmodule

// File: rtl/pnh_pullin.sv
// Prescaled pull-in timer; cleared whenever pull-in is not running.
module pnh_pullin #(
  parameter int PRESC  = 125,
  parameter int LEN_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             done_o
);
  localparam int PRE_W = (PRESC > 1) ? $clog2(PRESC) : 1;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             tick, endless, pre_en, cnt_en;

  always_comb begin
    tick    = (pre_q == PRE_W'(PRESC - 1));
    endless = &len_i;
    pre_en  = 1'b1;
    cnt_en  = !run_i || tick;
    if (!run_i) begin
      pre_d = '0;
      cnt_d = '0;
    end else begin
      pre_d = tick ? '0 : pre_q + 1'b1;
      cnt_d = cnt_q + 1'b1;
    end
    done_o = run_i && tick && !endless && (cnt_q == len_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      if (pre_en) pre_q <= pre_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  // R2: a timer that is not running holds no partial count
  a_r2_cleared_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (pre_q == '0) && (cnt_q == '0));
endmodule

// File: rtl/pnh_seq.sv
// Idle / pull-in / hold sequencer.
module pnh_seq
  import pnh_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable_i,
  input  logic      fault_i,
  input  logic      done_i,
  output pnh_mode_e mode_o
);
  pnh_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (!enable_i || fault_i) begin
      mode_d = MODE_IDLE;
    end else begin
      unique case (mode_q)
        MODE_IDLE: mode_d = MODE_PULL;
        MODE_PULL: mode_d = done_i ? MODE_HOLD : MODE_PULL;
        MODE_HOLD: mode_d = MODE_HOLD;
        default:   mode_d = MODE_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_IDLE;
    else        mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  // R1: a permitted request leaves idle for pull-in
  a_r1_idle_to_pull: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IDLE && enable_i && !fault_i) |=> (mode_q == MODE_PULL));
  // R9: hold is never entered straight from idle
  a_r9_no_direct_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IDLE) |=> (mode_q != MODE_HOLD));
endmodule

// File: rtl/pnh_driver.sv
// Peak-and-hold PWM load driver, top level.
module pnh_driver
  import pnh_pkg::*;
#(
  parameter int PERIOD = 5208,
  parameter int DUTY_W = 8,
  parameter int PRESC  = 125,
  parameter int PULL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              thermal_i,
  input  logic [DUTY_W-1:0] duty_code_i,
  input  logic [PULL_W-1:0] pull_len_i,
  output logic              gate_o,
  output logic [1:0]        mode_o
);
  localparam int TICK_W    = $clog2(PERIOD + 1);
  localparam int FULL      = 1 << DUTY_W;
  localparam int MIN_TICKS = (((FULL + 9) / 10) * PERIOD) / FULL;
  localparam int MAX_TICKS = (((9 * FULL) / 10) * PERIOD) / FULL;

  logic              rst_meta, rst_sync_n;
  logic [TICK_W-1:0] on_ticks;
  logic              pwm, pull_done;
  pnh_mode_e         mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  pnh_duty_map #(.PERIOD(PERIOD), .DUTY_W(DUTY_W), .TICK_W(TICK_W)) u_map (
    .code_i     (duty_code_i),
    .on_ticks_o (on_ticks)
  );

  pnh_carrier #(.PERIOD(PERIOD), .TICK_W(TICK_W),
                .MIN_TICKS(MIN_TICKS), .MAX_TICKS(MAX_TICKS)) u_carrier (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .on_ticks_i (on_ticks),
    .pwm_o      (pwm)
  );

  pnh_pullin #(.PRESC(PRESC), .LEN_W(PULL_W)) u_pullin (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run_i  (mode == MODE_PULL),
    .len_i  (pull_len_i),
    .done_o (pull_done)
  );

  pnh_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .enable_i (enable_i),
    .fault_i  (thermal_i),
    .done_i   (pull_done),
    .mode_o   (mode)
  );

  assign gate_o = (mode == MODE_PULL) || ((mode == MODE_HOLD) && pwm);
  assign mode_o = mode;

  // R7: a dropped request switches the load off by the next edge
  a_r7_disable_forces_off: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !enable_i |=> !gate_o);
  // R8: a thermal fault switches the load off by the next edge
  a_r8_fault_forces_off: assert property (@(posedge clk) disable iff (!rst_sync_n)
    thermal_i |=> (!gate_o && mode_o == 2'd0));
  // R3: endless pull-in setting never hands over to hold
  a_r3_endless_pull: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_o == 2'd1 && (&pull_len_i) && enable_i && !thermal_i) |=> (mode_o == 2'd1));
  // R10: only the three defined mode codes appear
  a_r10_mode_legal: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode_o != 2'd3);
endmodule

// File: tb/pnh_driver_test.sv
module pnh_driver_test;
  localparam int P  = 50;
  localparam int DW = 8;
  localparam int PS = 4;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          hot = 1'b0;
  logic [DW-1:0] code = 8'd128;
  logic [LW-1:0] plen = 4'd3;
  logic          gate;
  logic [1:0]    mode;
  int            tests = 0;
  int            fails = 0;
  int            cyc = 0;

  pnh_driver #(.PERIOD(P), .DUTY_W(DW), .PRESC(PS), .PULL_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .enable_i(en), .thermal_i(hot),
    .duty_code_i(code), .pull_len_i(plen), .gate_o(gate), .mode_o(mode)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_on(input int c);
    int lo = (256 + 9) / 10;
    int hi = (9 * 256) / 10;
    int k = (c < lo) ? lo : ((c > hi) ? hi : c);
    return (k * P) / 256;
  endfunction

  task automatic measure_pull(output int n, output int low);
    n = 0; low = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (mode != 2'd1) break;
      n++;
      if (!gate) low++;
    end
  endtask

  task automatic wait_rise(output int t);
    t = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!gate) break;
    end
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (gate) begin t = cyc; break; end
    end
  endtask

  // Current sample is a period start; counts high samples over one period.
  task automatic count_high(output int h);
    h = gate ? 1 : 0;
    for (int i = 1; i < P; i++) begin
      @(negedge clk);
      h += gate ? 1 : 0;
    end
  endtask

  task automatic go_idle();
    @(negedge clk); en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(gate == 1'b0 && mode == 2'd0, "R10 reset held", {gate, mode}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(gate == 1'b0 && mode == 2'd0, "R10 after reset", {gate, mode}, 0);
  endtask

  task automatic t_pull_and_hold();
    int n, low, t, h;
    code = 8'd128; plen = 4'd3;
    en = 1'b1;
    measure_pull(n, low);
    check(low == 0, "R1 gate high in pull-in", low, 0);
    check(n == 16, "R2 pull-in length L=3", n, 16);
    check(mode == 2'd2, "R10 hold code", mode, 2);
    wait_rise(t);
    count_high(h);
    check(h == exp_on(128), "R4 on-time code 128", h, exp_on(128));
    @(negedge clk);
    check(gate == 1'b1, "R4 next period starts after PERIOD", gate, 1);
  endtask

  task automatic t_clamp_one(input int c);
    int t, h;
    code = 8'(c);
    wait_rise(t); wait_rise(t);
    count_high(h);
    check(h == exp_on(c), $sformatf("R5 on-time code %0d", c), h, exp_on(c));
  endtask

  task automatic t_update();
    int t, h;
    code = 8'd128;
    wait_rise(t); wait_rise(t);
    code = 8'd230;
    count_high(h);
    check(h == exp_on(128), "R6 old duty kept in current period", h, exp_on(128));
    @(negedge clk);
    count_high(h);
    check(h == exp_on(230), "R6 new duty at next period", h, exp_on(230));
  endtask

  task automatic t_min_pull_and_disable();
    int n, low;
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    check(gate == 1'b0 && mode == 2'd0, "R7 disable turns off", {gate, mode}, 0);
    plen = 4'd0; en = 1'b1;
    measure_pull(n, low);
    check(n == PS, "R2 minimum pull-in L=0", n, PS);
  endtask

  task automatic t_phase();
    int t1, t2, n, low;
    code = 8'd128;
    wait_rise(t1);
    en = 1'b0;
    repeat (7) @(negedge clk);
    plen = 4'd0; en = 1'b1;
    measure_pull(n, low);
    wait_rise(t2);
    check(((t2 - t1) % P) == 0, "R4 carrier phase kept across enable", (t2 - t1) % P, 0);
  endtask

  task automatic t_endless();
    int bad = 0;
    go_idle();
    plen = 4'hF; en = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 300; i++) begin
      if (mode != 2'd1 || !gate) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R3 endless pull-in", bad, 0);
    go_idle();
  endtask

  task automatic t_fault();
    int n, low, bad = 0;
    plen = 4'd2; en = 1'b1;
    measure_pull(n, low);
    check(mode == 2'd2, "R10 in hold before fault", mode, 2);
    hot = 1'b1;
    @(negedge clk);
    check(gate == 1'b0 && mode == 2'd0, "R8 fault turns off", {gate, mode}, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (gate || mode != 2'd0) bad++;
    end
    check(bad == 0, "R8 stays idle during fault", bad, 0);
    hot = 1'b0;
    measure_pull(n, low);
    check(n == 12, "R9 full pull-in after recovery", n, 12);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        t_pull_and_hold();
        t_clamp_one(0);
        t_clamp_one(255);
        t_clamp_one(64);
        t_clamp_one(200);
        t_update();
        t_min_pull_and_disable();
        t_phase();
        t_endless();
        t_fault();
      end
      begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule